// File: doc/BRIEF.md
# Grouped Adjacent Key Suppression Arbiter

This block sits after the per-key touch confirmation stage of a ten-key capacitive sensor. Every cycle it receives a candidate flag for each key, the signal change measured on that key, and a mask marking which keys are fitted. It decides which candidates may be reported. Within each suppression domain only the dominant key survives. The dominant key is the one with the largest signal change. This stops one large finger from lighting several closely spaced keys.

The domain layout is chosen at run time. With suppression off, every fitted candidate is reported. In group mode there are three fixed domains, and keys in different domains never affect each other. In global mode all ten keys share one domain. A key that is already reported keeps its place unless a challenger's signal change is strictly larger, which prevents flicker between two keys of equal strength. The block also drives a combined detect output that is asserted while any key is reported, and its polarity is selectable.

Top module: `key_suppress_arbiter`

## Requirements
- R1: With mode code 1 (group mode) the domains are keys {0,1,4,5}, {2,3,6,7} and {8,9}, and at most one key of each domain is reported.
- R2: With mode code 2 (global mode) at most one key of the ten is reported.
- R3: With mode code 0 (suppression off) the reported vector equals candidate AND enable.
- R4: Within a domain the eligible candidate with the largest delta is reported, and the weaker candidates in that domain are suppressed.
- R5: A key whose enable bit is 0 is never reported, and it does not suppress any other key, whatever its delta is.
- R6: In group mode the winner of one domain does not depend on the candidates or deltas of another domain.
- R7: The detect output is the OR of the reported vector. It is driven high when the polarity input is 1 and driven low when the polarity input is 0. When no key is reported it sits at the opposite level.
- R8: When two keys that were not reported in the previous cycle tie on delta, the lower-numbered key wins.
- R9: A key reported in the previous cycle that is still an eligible candidate keeps its place against a challenger with an equal or smaller delta. A challenger with a strictly larger delta takes over.
- R10: The reported vector is registered. It reflects the inputs sampled at the previous rising clock edge, and it is all zero after a synchronous reset.
- R11: Mode code 3 behaves exactly like global mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 2 | 0 off, 1 three groups, 2 or 3 global |
| det_high_i | input | 1 | 1: detect is active high; 0: detect is active low |
| key_en_i | input | 10 | Per-key fitted mask, bit k for key k |
| cand_i | input | 10 | Per-key confirmed candidate flags |
| delta_i | input | 10*DW | Per-key signal change, key k at bits [k*DW +: DW] |
| key_state_o | output | 10 | Reported key states after suppression |
| detect_o | output | 1 | Any key reported, at the selected polarity |

## Verification
A wrong domain map or a broken comparison shows up on key_state_o one cycle after the offending inputs. It appears either as two keys lit in one domain or as a weaker key lit instead of the stronger one. A corrupted incumbent register is harder to see. It only becomes visible when a challenger ties the current owner, and then the wrong key wins on the following cycle. For that reason tie stimulus is applied both with and without a previous owner. A fault in the polarity handling shows on detect_o in the same cycle that key_state_o changes.

// File: rtl/key_suppress_pkg.sv
package key_suppress_pkg;

    localparam int NKEYS = 10;
    localparam int NDOM  = 3;

    typedef enum logic [1:0] {
        SUP_OFF     = 2'd0,
        SUP_GROUP   = 2'd1,
        SUP_GLOBAL  = 2'd2,
        SUP_GLOBAL2 = 2'd3
    } sup_mode_e;

    typedef logic [NKEYS-1:0] key_vec_t;

    // fixed hardware group of each key in group mode
    function automatic int group_of(input int k);
        case (k)
            0, 1, 4, 5: return 0;
            2, 3, 6, 7: return 1;
            default:    return 2;
        endcase
    endfunction

    // members of domain d under a given mode
    function automatic key_vec_t domain_mask(input sup_mode_e m, input int d);
        key_vec_t v;
        v = '0;
        for (int k = 0; k < NKEYS; k++) begin
            case (m)
                SUP_GROUP:               v[k] = (group_of(k) == d);
                SUP_GLOBAL, SUP_GLOBAL2: v[k] = (d == 0);
                default:                 v[k] = 1'b0;
            endcase
        end
        return v;
    endfunction

endpackage

// File: rtl/sup_domain_pick.sv
module sup_domain_pick #(
    parameter int N  = 10,
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N-1:0]    member_i,
    input  logic [N-1:0]    elig_i,
    input  logic [N-1:0]    inc_i,
    input  logic [N*DW-1:0] delta_i,
    output logic [N-1:0]    win_o
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [DW-1:0] best_d;
    logic [IW-1:0] best_idx;
    logic          have;
    logic          best_inc;
    logic          take;
    logic [DW-1:0] d;

    // ascending scan: strict greater wins, an incumbent wins an equal tie
    always_comb begin
        best_d   = '0;
        best_idx = '0;
        have     = 1'b0;
        best_inc = 1'b0;
        take     = 1'b0;
        d        = '0;
        win_o    = '0;
        for (int k = 0; k < N; k++) begin
            if (member_i[k] && elig_i[k]) begin
                d    = delta_i[k*DW +: DW];
                take = !have || (d > best_d) ||
                       ((d == best_d) && inc_i[k] && !best_inc);
                if (take) begin
                    have     = 1'b1;
                    best_d   = d;
                    best_inc = inc_i[k];
                    best_idx = IW'(k);
                end
            end
        end
        if (have) win_o[best_idx] = 1'b1;
    end

    // R1 R2: a domain yields at most one winner, drawn from its eligible members
    p_single_winner_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(win_o) && ((win_o & ~(member_i & elig_i)) == '0));

endmodule

// File: rtl/sup_det_drive.sv
module sup_det_drive #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] state_i,
    input  logic         high_i,
    output logic         det_o
);
    logic any_on;

    always_comb begin
        any_on = |state_i;
        det_o  = high_i ? any_on : !any_on;
    end

    // R7: detect output level follows polarity whenever a key is reported
    p_detect_level_r7: assert property (@(posedge clk) disable iff (rst)
        (state_i != '0) |-> (det_o == high_i));

endmodule

// File: rtl/key_suppress_arbiter.sv
module key_suppress_arbiter
    import key_suppress_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          mode_i,
    input  logic                det_high_i,
    input  logic [NKEYS-1:0]    key_en_i,
    input  logic [NKEYS-1:0]    cand_i,
    input  logic [NKEYS*DW-1:0] delta_i,
    output logic [NKEYS-1:0]    key_state_o,
    output logic                detect_o
);
    sup_mode_e mode;
    key_vec_t  elig;
    key_vec_t  incumb;
    key_vec_t  nxt;
    key_vec_t  state_q;
    key_vec_t  dom_mask [NDOM];
    key_vec_t  dom_win  [NDOM];

    always_comb begin
        mode   = sup_mode_e'(mode_i);
        elig   = cand_i & key_en_i;
        incumb = state_q & elig;
    end

    for (genvar g = 0; g < NDOM; g++) begin : g_dom
        assign dom_mask[g] = domain_mask(mode, g);

        sup_domain_pick #(
            .N  (NKEYS),
            .DW (DW)
        ) u_pick (
            .clk      (clk),
            .rst      (rst),
            .member_i (dom_mask[g]),
            .elig_i   (elig),
            .inc_i    (incumb),
            .delta_i  (delta_i),
            .win_o    (dom_win[g])
        );
    end

    always_comb begin
        if (mode == SUP_OFF) begin
            nxt = elig;
        end else begin
            nxt = '0;
            for (int g = 0; g < NDOM; g++) nxt = nxt | dom_win[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= nxt;
    end

    assign key_state_o = state_q;

    sup_det_drive #(
        .N (NKEYS)
    ) u_det (
        .clk     (clk),
        .rst     (rst),
        .state_i (state_q),
        .high_i  (det_high_i),
        .det_o   (detect_o)
    );

    // R2 R11: global modes leave at most one key reported
    p_global_one_r2: assert property (@(posedge clk) disable iff (rst)
        (mode_i[1]) |=> $onehot0(key_state_o));

    // R1: group mode leaves at most one key per fixed group
    p_group_one_r1: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'd1) |=> ($onehot0({key_state_o[5:4], key_state_o[1:0]}) &&
                              $onehot0({key_state_o[7:6], key_state_o[3:2]}) &&
                              $onehot0(key_state_o[9:8])));

    // R3: no suppression passes fitted candidates through
    p_off_pass_r3: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'd0) |=> (key_state_o == $past(cand_i & key_en_i)));

    // R5: unfitted keys are never reported
    p_unused_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((key_state_o & ~$past(key_en_i)) == '0));

endmodule

// File: tb/key_suppress_arbiter_tb.sv
`timescale 1ns/1ps
module key_suppress_arbiter_tb;
    localparam int NK = 10;
    localparam int DW = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic [1:0]        mode;
    logic              pol;
    logic [NK-1:0]     en;
    logic [NK-1:0]     cand;
    logic [NK*DW-1:0]  delta;
    logic [NK-1:0]     ks;
    logic              det;

    int checks = 0;
    int errors = 0;
    logic [NK-1:0] exp_state;
    logic [DW-1:0] dl [NK];

    always #2.5 clk = ~clk;

    key_suppress_arbiter #(.DW(DW)) u_dut (
        .clk(clk), .rst(rst), .mode_i(mode), .det_high_i(pol),
        .key_en_i(en), .cand_i(cand), .delta_i(delta),
        .key_state_o(ks), .detect_o(det)
    );

    function automatic int dom_id(input logic [1:0] m, input int k);
        if (m[1]) return 0;
        if (k == 0 || k == 1 || k == 4 || k == 5) return 0;
        if (k == 8 || k == 9) return 2;
        return 1;
    endfunction

    function automatic logic [NK-1:0] model(input logic [NK-1:0] prev,
                                            input logic [1:0] m,
                                            input logic [NK-1:0] c,
                                            input logic [NK-1:0] e);
        logic [NK-1:0] r;
        logic [NK-1:0] ok;
        r  = '0;
        ok = c & e;
        if (m == 2'd0) return ok;
        for (int dd = 0; dd < 3; dd++) begin
            int bi;
            bi = -1;
            for (int k = 0; k < NK; k++) begin
                if (ok[k] && dom_id(m, k) == dd) begin
                    if (bi < 0) bi = k;
                    else if (dl[k] > dl[bi]) bi = k;
                    else if (dl[k] == dl[bi] && prev[k] && !(prev[bi] && ok[bi])) bi = k;
                end
            end
            if (bi >= 0) r[bi] = 1'b1;
        end
        return r;
    endfunction

    task automatic pack();
        for (int k = 0; k < NK; k++) delta[k*DW +: DW] = dl[k];
    endtask

    task automatic check_out(input string tag);
        logic exp_det;
        exp_det = pol ? (|exp_state) : !(|exp_state);
        checks++;
        if (ks !== exp_state) begin
            errors++;
            $display("FAIL %s key_state actual=%b expected=%b", tag, ks, exp_state);
        end
        checks++;
        if (det !== exp_det) begin
            errors++;
            $display("FAIL R7 (%s) detect actual=%b expected=%b", tag, det, exp_det);
        end
    endtask

    task automatic step(input string tag);
        pack();
        exp_state = model(exp_state, mode, cand, en);
        @(posedge clk); #1;
        check_out(tag);
    endtask

    task automatic set_d(input int k, input int v);
        dl[k] = DW'(v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst = 1'b1; mode = 2'd1; pol = 1'b1; en = '1; cand = '0;
        for (int k = 0; k < NK; k++) dl[k] = '0;
        pack();
        exp_state = '0;
        repeat (3) @(posedge clk);
        #1;
        check_out("R10 reset");
        rst = 1'b0;

        // R4: stronger key in group wins
        cand = 10'b00_0000_0011; set_d(0, 3); set_d(1, 5);
        step("R4 stronger");
        checks++;
        if (ks !== 10'b00_0000_0010) begin errors++; $display("FAIL R4 actual=%b expected=%b", ks, 10'b10); end
        // R9: incumbent keeps on tie
        set_d(0, 6); set_d(1, 6);
        step("R9 hold");
        checks++;
        if (ks !== 10'b00_0000_0010) begin errors++; $display("FAIL R9 actual=%b expected=%b", ks, 10'b10); end
        // R9: strictly larger challenger takes over
        set_d(0, 7);
        step("R9 takeover");
        checks++;
        if (ks !== 10'b00_0000_0001) begin errors++; $display("FAIL R9 actual=%b expected=%b", ks, 10'b01); end
        // R8: tie between fresh keys
        cand = '0; step("R8 clear");
        cand = 10'b00_0001_0001; set_d(0, 4); set_d(4, 4);
        step("R8 tie");
        checks++;
        if (ks !== 10'b00_0000_0001) begin errors++; $display("FAIL R8 actual=%b expected=%b", ks, 10'b01); end
        // R6: groups independent
        cand = 10'b11_0000_0101; set_d(2, 1); set_d(8, 2); set_d(9, 9);
        step("R6 groups");
        checks++;
        if (ks !== 10'b10_0000_0101) begin errors++; $display("FAIL R6 actual=%b expected=%b", ks, 10'b1000000101); end
        // R5: disabled strong key neither reported nor suppressing
        cand = '0; step("R5 clear");
        en = 10'b11_1111_1101; cand = 10'b00_0000_0011; set_d(0, 1); set_d(1, 200);
        step("R5 unused");
        checks++;
        if (ks !== 10'b00_0000_0001) begin errors++; $display("FAIL R5 actual=%b expected=%b", ks, 10'b01); end
        en = '1;
        // R2: global
        mode = 2'd2; cand = '1;
        for (int k = 0; k < NK; k++) set_d(k, k + 1);
        step("R2 global");
        checks++;
        if (ks !== 10'b10_0000_0000) begin errors++; $display("FAIL R2 actual=%b expected=%b", ks, 10'b1000000000); end
        // R11: mode 3 same as global
        mode = 2'd3; set_d(3, 50);
        step("R11 mode3");
        checks++;
        if (ks !== 10'b00_0000_1000) begin errors++; $display("FAIL R11 actual=%b expected=%b", ks, 10'b1000); end
        // R3: off mode
        mode = 2'd0; cand = 10'b10_1100_1011;
        step("R3 off");
        // R7: active-low polarity
        pol = 1'b0; step("R7 low active");
        cand = '0; step("R7 low idle");
        pol = 1'b1; step("R7 high idle");

        // random mix over all modes
        for (int it = 0; it < 2000; it++) begin
            if (it % 100 == 0) mode = 2'($urandom_range(0, 3));
            pol  = 1'($urandom);
            cand = NK'($urandom);
            en   = ($urandom_range(0, 3) == 0) ? NK'($urandom) : '1;
            for (int k = 0; k < NK; k++) dl[k] = DW'($urandom_range(0, 7));
            case (mode)
                2'd0:    step("R3 random");
                2'd1:    step("R1 random");
                2'd2:    step("R2 random");
                default: step("R11 random");
            endcase
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule